// File: doc/BRIEF.md
# Guarded Control Register Write Sequencer

This block protects a four-bit configuration field with an unlock sequence. The field holds a two-bit watchdog select and a two-bit power-up delay select. It also arbitrates writes into a 512-byte memory array that may be partly write-locked. The serial bus layer is outside the block. It sees each bus transaction as three kinds of event: a start pulse that carries a kind code and a start address, data-byte pulses, and a stop pulse. For every data byte of a write transaction it returns an acknowledge or a not-acknowledge.

The configuration field only changes at the end of a three-step exchange. The first step raises a volatile write-enable latch. The second step raises a volatile register-enable latch. The third step is a single-byte control write whose bit pattern carries the new field. Each step is a control-register write transaction that holds exactly one data byte. Read transactions may come between the steps without breaking the exchange. A commit starts a busy period of programmable length. Write transactions that begin during that period are refused. A write attempt into the locked half of the array is dropped, and it also clears the register-enable latch.

Transaction kind codes, sampled with the start pulse: 0 is a control-register write, 1 is a memory write, 2 is a read, and 3 is handled like a read.

Top module: `cfg_guard`

## Requirements
- R1: After reset, both latches are 0, busy is 0, no acknowledge or memory write is signalled, and the watchdog and delay fields hold their init parameters (default 00).
- R2: A control write made of the single byte 02h, ended by a stop, sets the write-enable latch from the stop's clock edge on. The register-enable latch does not change and busy stays 0.
- R3: A single byte 06h with the write-enable latch set raises the register-enable latch and keeps write-enable set. A 06h sent while write-enable is clear is ignored. Any other byte is not taken as the unlock, for example 0Eh or 07h.
- R4: With the register-enable latch set, a single byte whose bits [4:3] are 00, bit 1 is 1 and bit 2 is 0 commits. The watchdog field takes {bit6, bit5} and the delay field takes {bit7, bit0}. The register-enable latch clears, the write-enable latch stays set, and busy is high for exactly COMMIT_CYCLES cycles, starting at the stop's edge. So 02h, 06h, 02h commits all zeros.
- R5: With the register-enable latch set, a byte of the same form but with bit 2 set (06h, for example) leaves both fields unchanged and keeps the register-enable latch set. A byte that does not have the form, such as 12h, is ignored.
- R6: In a control write, the first data byte is acknowledged and every later byte gets not-acknowledge. Such a transaction changes no latch and no field.
- R7: A read transaction produces no acknowledge and does not alter the latches, so an unlock exchange continues across it.
- R8: A memory write byte aimed at a locked address is dropped and clears the register-enable latch, yet it is still acknowledged.
- R9: The upper half of the array (address bit 8 set) is locked only while protEn is 1. Otherwise every memory write byte pulses memWe, with its address and data, one cycle after the byte.
- R10: Every data byte of a write transaction started while busy is high gets not-acknowledge. The transaction has no effect.
- R11: ackValid pulses one cycle after each data byte of a write transaction. Within a memory write, each further byte goes to the next address, wrapping within ADDR_W bits.
- R12: A control write that ends with no data byte changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, models a power cycle |
| txStart | input | 1 | Transaction start pulse |
| txKind | input | 2 | Transaction kind, sampled with txStart |
| txAddr | input | ADDR_W | Memory start address, sampled with txStart |
| byteValid | input | 1 | Data byte pulse |
| byteData | input | 8 | Data byte value |
| txStop | input | 1 | Transaction stop pulse |
| protEn | input | 1 | Lock for the upper half of the array |
| ackValid | output | 1 | Byte response valid |
| ackNak | output | 1 | 1 = not-acknowledge |
| busy | output | 1 | Commit in progress |
| wrEnable | output | 1 | Write-enable latch |
| regEnable | output | 1 | Register-enable latch |
| wdogSel | output | 2 | Watchdog select field |
| dlySel | output | 2 | Power-up delay select field |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | ADDR_W | Memory write address |
| memData | output | 8 | Memory write data |

## Verification
The hardest case to reach is a protected write attempt that arrives partway through a memory transaction. The bench first brings the register-enable latch up through the unlock exchange. It then starts a memory write at the last unlocked address, 0FFh. The address step on the second byte moves into the locked half, so one transaction yields one real write and one dropped write, and the latch clears at that exact byte. Refusal during busy is hard to reach for the same kind of reason. It is reached by starting transactions right after a commit's stop edge, while the timer is still counting.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;

  localparam logic [1:0] KIND_CTL = 2'd0;
  localparam logic [1:0] KIND_MEM = 2'd1;

  localparam logic [7:0] BYTE_ARM   = 8'h02;
  localparam logic [7:0] BYTE_ARM2  = 8'h06;

  // strobes from the transaction control to the latch/field datapath
  typedef struct packed {
    logic       ackStb;
    logic       ackNak;
    logic       setWr;
    logic       setReg;
    logic       clrReg;
    logic       commit;
    logic [1:0] newWdog;
    logic [1:0] newDly;
  } guardStrb_t;

endpackage

// File: rtl/cfg_guard_ctrl.sv
module cfg_guard_ctrl
  import cfg_guard_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txStart,
  input  logic [1:0]        txKind,
  input  logic [ADDR_W-1:0] txAddr,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              txStop,
  input  logic              protEn,
  input  logic              wrEnable,
  input  logic              regEnable,
  input  logic              busy,
  output guardStrb_t        strb,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData
);

  logic              inTx;
  logic [1:0]        kindQ;
  logic              blockedQ;
  logic [1:0]        byteCnt;
  logic [7:0]        pendQ;
  logic [ADDR_W-1:0] addrQ;

  logic isCtl, isMem, isWrite, byteHit, protHit, memWrNext, formOk;

  assign isCtl     = (kindQ == KIND_CTL);
  assign isMem     = (kindQ == KIND_MEM);
  assign isWrite   = isCtl || isMem;
  assign byteHit   = inTx && byteValid && isWrite;
  assign protHit   = protEn && addrQ[ADDR_W-1];
  assign memWrNext = byteHit && isMem && !blockedQ && !protHit;
  assign formOk    = (pendQ[4:3] == 2'b00) && pendQ[1];

  always_comb begin
    strb         = '0;
    strb.newWdog = pendQ[6:5];
    strb.newDly  = {pendQ[7], pendQ[0]};
    if (byteHit) begin
      strb.ackStb = 1'b1;
      if (blockedQ)   strb.ackNak = 1'b1;
      else if (isCtl) strb.ackNak = (byteCnt != 2'd0);
      else if (protHit) strb.clrReg = 1'b1;
    end
    if (inTx && txStop && isCtl && !blockedQ && byteCnt == 2'd1) begin
      if (regEnable) begin
        if (formOk && !pendQ[2]) strb.commit = 1'b1;
      end else if (pendQ == BYTE_ARM) begin
        strb.setWr = 1'b1;
      end else if (pendQ == BYTE_ARM2 && wrEnable) begin
        strb.setReg = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inTx     <= 1'b0;
      kindQ    <= 2'd2;
      blockedQ <= 1'b0;
      byteCnt  <= 2'd0;
      pendQ    <= 8'h00;
      addrQ    <= '0;
    end else if (txStart) begin
      inTx     <= 1'b1;
      kindQ    <= txKind;
      blockedQ <= busy && (txKind == KIND_CTL || txKind == KIND_MEM);
      byteCnt  <= 2'd0;
      addrQ    <= txAddr;
    end else if (txStop) begin
      inTx <= 1'b0;
    end else if (inTx && byteValid) begin
      if (byteCnt != 2'd2) byteCnt <= byteCnt + 2'd1;
      if (byteCnt == 2'd0) pendQ <= byteData;
      if (isMem) addrQ <= addrQ + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      memWe   <= 1'b0;
      memAddr <= '0;
      memData <= 8'h00;
    end else begin
      memWe <= memWrNext;
      if (memWrNext) begin
        memAddr <= addrQ;
        memData <= byteData;
      end
    end
  end

endmodule

// File: rtl/cfg_guard_dp.sv
module cfg_guard_dp
  import cfg_guard_pkg::*;
#(
  parameter int         COMMIT_CYCLES = 16,
  parameter logic [1:0] WDOG_INIT     = 2'b00,
  parameter logic [1:0] DLY_INIT      = 2'b00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  guardStrb_t strb,
  output logic       wrEnable,
  output logic       regEnable,
  output logic       busy,
  output logic [1:0] wdogSel,
  output logic [1:0] dlySel,
  output logic       ackValid,
  output logic       ackNak
);

  localparam int CNT_W = $clog2(COMMIT_CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  assign busy = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrEnable  <= 1'b0;
      regEnable <= 1'b0;
      wdogSel   <= WDOG_INIT;
      dlySel    <= DLY_INIT;
      cnt       <= '0;
      ackValid  <= 1'b0;
      ackNak    <= 1'b0;
    end else begin
      ackValid <= strb.ackStb;
      ackNak   <= strb.ackStb && strb.ackNak;
      if (strb.setWr || strb.setReg) wrEnable <= 1'b1;
      if (strb.clrReg || strb.commit) regEnable <= 1'b0;
      else if (strb.setReg)           regEnable <= 1'b1;
      if (strb.commit) begin
        wdogSel <= strb.newWdog;
        dlySel  <= strb.newDly;
        cnt     <= CNT_W'(COMMIT_CYCLES);
      end else if (cnt != '0) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/cfg_guard.sv
module cfg_guard
  import cfg_guard_pkg::*;
#(
  parameter int         ADDR_W        = 9,
  parameter int         COMMIT_CYCLES = 16,
  parameter logic [1:0] WDOG_INIT     = 2'b00,
  parameter logic [1:0] DLY_INIT      = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txStart,
  input  logic [1:0]        txKind,
  input  logic [ADDR_W-1:0] txAddr,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              txStop,
  input  logic              protEn,
  output logic              ackValid,
  output logic              ackNak,
  output logic              busy,
  output logic              wrEnable,
  output logic              regEnable,
  output logic [1:0]        wdogSel,
  output logic [1:0]        dlySel,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData
);

  guardStrb_t strb;

  cfg_guard_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .txStart(txStart), .txKind(txKind),
    .txAddr(txAddr), .byteValid(byteValid), .byteData(byteData),
    .txStop(txStop), .protEn(protEn), .wrEnable(wrEnable),
    .regEnable(regEnable), .busy(busy), .strb(strb),
    .memWe(memWe), .memAddr(memAddr), .memData(memData)
  );

  cfg_guard_dp #(
    .COMMIT_CYCLES(COMMIT_CYCLES), .WDOG_INIT(WDOG_INIT), .DLY_INIT(DLY_INIT)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrEnable(wrEnable),
    .regEnable(regEnable), .busy(busy), .wdogSel(wdogSel), .dlySel(dlySel),
    .ackValid(ackValid), .ackNak(ackNak)
  );

endmodule

// File: rtl/cfg_guard_chk.sv
module cfg_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txStop,
  input logic       byteValid,
  input logic       busy,
  input logic       wrEnable,
  input logic       regEnable,
  input logic [1:0] wdogSel,
  input logic [1:0] dlySel,
  input logic       ackValid,
  input logic       memWe
);

  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(txStop));

  // R2
  wr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrEnable) |-> $past(txStop));

  // R8
  reg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(regEnable) |-> ($past(txStop) || $past(byteValid)));

  // R11
  ack_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ackValid |-> $past(byteValid));

  // R4
  field_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({wdogSel, dlySel}) |-> ($rose(busy) && $past(regEnable)));

  // R10
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> !$past(busy));

endmodule

bind cfg_guard cfg_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txStop(txStop), .byteValid(byteValid),
  .busy(busy), .wrEnable(wrEnable), .regEnable(regEnable),
  .wdogSel(wdogSel), .dlySel(dlySel), .ackValid(ackValid), .memWe(memWe)
);

// File: tb/cfg_guard_tb.sv
module cfg_guard_tb;

  localparam int ADDR_W = 9;
  localparam int COMMIT = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic txStart = 0, byteValid = 0, txStop = 0, protEn = 0;
  logic [1:0] txKind = 2'd2;
  logic [ADDR_W-1:0] txAddr = '0;
  logic [7:0] byteData = 8'h00;
  logic ackValid, ackNak, busy, wrEnable, regEnable, memWe;
  logic [1:0] wdogSel, dlySel;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0] memData;

  int checks = 0, errors = 0;
  bit done = 0;
  logic sAck, sNak, sWe;
  logic [ADDR_W-1:0] sAddr;
  logic [7:0] sData;

  always #5 clk = ~clk;

  cfg_guard #(.ADDR_W(ADDR_W), .COMMIT_CYCLES(COMMIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .txStart(txStart), .txKind(txKind),
    .txAddr(txAddr), .byteValid(byteValid), .byteData(byteData),
    .txStop(txStop), .protEn(protEn), .ackValid(ackValid), .ackNak(ackNak),
    .busy(busy), .wrEnable(wrEnable), .regEnable(regEnable),
    .wdogSel(wdogSel), .dlySel(dlySel), .memWe(memWe), .memAddr(memAddr),
    .memData(memData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic startTx(input logic [1:0] k, input logic [ADDR_W-1:0] a);
    txStart = 1; txKind = k; txAddr = a;
    @(negedge clk);
    txStart = 0;
  endtask

  task automatic sendByte(input logic [7:0] d);
    byteValid = 1; byteData = d;
    @(negedge clk);
    byteValid = 0;
    sAck = ackValid; sNak = ackNak; sWe = memWe; sAddr = memAddr; sData = memData;
  endtask

  task automatic stopTx();
    txStop = 1;
    @(negedge clk);
    txStop = 0;
  endtask

  task automatic ctlWrite(input logic [7:0] d);
    startTx(2'd0, '0); sendByte(d); stopTx();
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic unlock();
    ctlWrite(8'h02); ctlWrite(8'h06);
  endtask

  task automatic t_reset();
    doReset();
    chk("R1 wrEnable", wrEnable, 0);
    chk("R1 regEnable", regEnable, 0);
    chk("R1 busy", busy, 0);
    chk("R1 fields", {wdogSel, dlySel}, 4'b0000);
    chk("R1 no ack/we", {ackValid, memWe}, 2'b00);
  endtask

  task automatic t_unlock_commit();
    int n;
    doReset();
    ctlWrite(8'h02);
    chk("R2 wr set", wrEnable, 1);
    chk("R2 reg clear", regEnable, 0);
    chk("R2 no busy", busy, 0);
    ctlWrite(8'h06);
    chk("R3 reg set", {wrEnable, regEnable}, 2'b11);
    ctlWrite(8'hE3);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R4 busy cycles", n, COMMIT);
    chk("R4 fields E3", {wdogSel, dlySel}, 4'b1111);
    chk("R4 latches after", {wrEnable, regEnable}, 2'b10);
    unlock(); ctlWrite(8'h02); waitIdle();
    chk("R4 02,06,02 zero", {wdogSel, dlySel}, 4'b0000);
  endtask

  task automatic t_keep();
    doReset();
    unlock(); ctlWrite(8'hE3); waitIdle();
    unlock(); ctlWrite(8'h06);
    chk("R5 keep fields", {wdogSel, dlySel}, 4'b1111);
    chk("R5 reg stays", regEnable, 1);
    chk("R5 no busy", busy, 0);
    ctlWrite(8'h12);
    chk("R5 bad form ignored", {regEnable, wdogSel, dlySel}, 5'b11111);
    ctlWrite(8'h42); waitIdle();
    chk("R4 fields 42", {wdogSel, dlySel}, 4'b1000);
  endtask

  task automatic t_bad_unlock();
    doReset();
    ctlWrite(8'h06);
    chk("R3 06 without wr", {wrEnable, regEnable}, 2'b00);
    ctlWrite(8'h02);
    ctlWrite(8'h0E);
    chk("R3 0E rejected", regEnable, 0);
    ctlWrite(8'h07);
    chk("R3 07 rejected", regEnable, 0);
  endtask

  task automatic t_two_bytes();
    doReset();
    startTx(2'd0, '0);
    sendByte(8'h02);
    chk("R6 first ack", {sAck, sNak}, 2'b10);
    sendByte(8'h02);
    chk("R6 second nak", {sAck, sNak}, 2'b11);
    stopTx();
    chk("R6 no effect", {wrEnable, regEnable, busy}, 3'b000);
    startTx(2'd0, '0); stopTx();
    chk("R12 empty ctl", {wrEnable, regEnable, busy}, 3'b000);
  endtask

  task automatic t_read_between();
    doReset();
    ctlWrite(8'h02);
    startTx(2'd2, '0); sendByte(8'hFF);
    chk("R7 no ack on read", sAck, 0);
    stopTx();
    ctlWrite(8'h06);
    startTx(2'd2, '0); sendByte(8'h00); stopTx();
    chk("R7 latches kept", {wrEnable, regEnable}, 2'b11);
    ctlWrite(8'h22); waitIdle();
    chk("R7 commit after reads", {wdogSel, dlySel, regEnable}, 5'b01000);
  endtask

  task automatic t_protect();
    doReset();
    protEn = 1;
    unlock();
    startTx(2'd1, 9'h0FF);
    sendByte(8'hA5);
    chk("R11 ack mem", {sAck, sNak}, 2'b10);
    chk("R9 lower write", {sWe, sAddr, sData}, {1'b1, 9'h0FF, 8'hA5});
    sendByte(8'h5A);
    chk("R8 locked dropped", sWe, 0);
    chk("R8 still acked", {sAck, sNak}, 2'b10);
    chk("R8 reg cleared", regEnable, 0);
    stopTx();
    protEn = 0;
    startTx(2'd1, 9'h1FF);
    sendByte(8'h3C);
    chk("R9 unlocked upper", {sWe, sAddr, sData}, {1'b1, 9'h1FF, 8'h3C});
    sendByte(8'hC3);
    chk("R11 addr wrap", {sWe, sAddr, sData}, {1'b1, 9'h000, 8'hC3});
    stopTx();
  endtask

  task automatic t_busy();
    doReset();
    unlock(); ctlWrite(8'h02);
    chk("R10 busy on", busy, 1);
    startTx(2'd1, 9'h010); sendByte(8'h77);
    chk("R10 mem nak", {sAck, sNak, sWe}, 3'b110);
    stopTx();
    ctlWrite(8'h06);
    chk("R10 ctl nak", {sAck, sNak}, 2'b11);
    chk("R10 no unlock", regEnable, 0);
    waitIdle();
    ctlWrite(8'h06);
    chk("R10 after busy", regEnable, 1);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_unlock_commit();
    t_keep();
    t_bad_unlock();
    t_two_bytes();
    t_read_between();
    t_protect();
    t_busy();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule